// File: doc/BRIEF.md
# DMA channel register block

This block holds the per-channel registers of a descriptor-driven DMA engine and applies the rules that move the channel between idle, running, paused and flushing. Software reaches it through 32-bit register accesses into a 256-byte channel window. The sequencer and the data path read the results on dedicated outputs.

Software changes the channel state through a write-only control word. Its upper half is a per-bit enable and its lower half holds the new bit values. After the merge, a fixed set of precedence rules settles the ACTIVE bit. A flush request is sent to the data path as a one-cycle pulse. A start pulse wakes the sequencer whenever the channel is left active. A write to the command pointer, when it is accepted, aligns the pointer and pulses a fetch request.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every stored register is zero. Reads of every word return zero, and flush_req_o, kick_o and fetch_o are low.
- R2: A write to word 0 (control) forms the next status as ((wdata[15:0] & 16'hF0FF) & wdata[31:16]) | (status & ~wdata[31:16]). Status bits are: run 15, pause 14, flush 13, wake 12, dead 11, active 10, branch-taken 8, device status 7:0. A masked non-writable bit therefore becomes 0.
- R3: If the merged status has wake or run set, the stored active bit is 1, unless R4 or R5 applies. Run set also clears dead.
- R4: If the merged status has pause set, the stored active bit is 0.
- R5: If run was 1 before a control write and is 0 after it, active and dead are both stored as 0. This holds even when wake is set.
- R6: If the merged status has flush set, flush_req_o is high for exactly the cycle after the write, and the stored flush bit is 0.
- R7: kick_o is high for exactly the cycle after a control write that leaves active at 1.
- R8: Word 0 reads as zero. Words 1 (status, in bits 15:0), 3 (command pointer), 4 (interrupt select), 5 (branch select) and 6 (wait select) read back their stored values. Words 4 to 6 store all 32 bits. Word 2 and words 7 to 63 read as zero, and writes to them and to word 1 change nothing.
- R9: A write to word 3 is ignored while active is 1. Otherwise it stores wdata with bits 3:0 cleared, and fetch_o is high for exactly the cycle after it.
- R10: An access with be_i other than 4'hF, or with addr_i[1:0] nonzero, is invalid. An invalid write changes no register and raises no pulse, and an invalid read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the current access |
| be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| addr_i | input | 8 | Byte address inside the channel window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| status_o | output | 16 | Current channel status |
| cmd_ptr_o | output | 32 | Current command pointer |
| intr_sel_o | output | 32 | Interrupt condition select |
| br_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| flush_req_o | output | 1 | One-cycle flush request to the data path |
| kick_o | output | 1 | One-cycle start request to the sequencer |
| fetch_o | output | 1 | One-cycle descriptor fetch request |

## Verification
The bench drives control words in which wake and run are set together with pause, or with a falling run. A design that applies the precedence rules in the wrong order would leave active set in those cases, and later pointer writes would be refused. Control masks that cover the read-only active and dead bits check that masked bits are cleared rather than kept. A design that keeps them shows stale state. Pointer writes are made while the channel is active, and partial or misaligned accesses are mixed in. A design that ignores either guard changes stored state or fires fetch pulses when it should not.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned WIN_BYTES = 256;
  localparam int unsigned ADDR_W    = $clog2(WIN_BYTES);
  localparam int unsigned WORD_W    = ADDR_W - 2;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned BE_W      = DATA_W / 8;

  localparam int unsigned B_RUN   = 15;
  localparam int unsigned B_PAUSE = 14;
  localparam int unsigned B_FLUSH = 13;
  localparam int unsigned B_WAKE  = 12;
  localparam int unsigned B_DEAD  = 11;
  localparam int unsigned B_ACT   = 10;

  localparam logic [STAT_W-1:0] WR_BITS = 16'hF0FF;

  typedef enum logic [WORD_W-1:0] {
    W_CTRL   = 6'd0,
    W_STAT   = 6'd1,
    W_CP_HI  = 6'd2,
    W_CP_LO  = 6'd3,
    W_ISEL   = 6'd4,
    W_BSEL   = 6'd5,
    W_WSEL   = 6'd6
  } reg_word_e;
endpackage

// File: rtl/dma_ctl_next.sv
module dma_ctl_next
  import dma_chan_pkg::*;
(
  input  logic [STAT_W-1:0] old_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_W-1:0] new_o,
  output logic              flush_o,
  output logic              kick_o
);
  logic [STAT_W-1:0] mask, val, s;

  always_comb begin
    mask = wdata_i[DATA_W-1:STAT_W];
    val  = wdata_i[STAT_W-1:0] & WR_BITS;
    s    = (val & mask) | (old_i & ~mask);
    if (s[B_WAKE]) s[B_ACT] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACT]  = 1'b1;
      s[B_DEAD] = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACT] = 1'b0;
    if (old_i[B_RUN] && !s[B_RUN]) begin
      s[B_ACT]  = 1'b0;
      s[B_DEAD] = 1'b0;
    end
    flush_o = s[B_FLUSH];
    s[B_FLUSH] = 1'b0;
    kick_o = s[B_ACT];
    new_o  = s;
  end
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_chan_pkg::*;
(
  input  logic              ok_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [DATA_W-1:0] cmd_ptr_i,
  input  logic [DATA_W-1:0] isel_i,
  input  logic [DATA_W-1:0] bsel_i,
  input  logic [DATA_W-1:0] wsel_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (ok_i) begin
      unique case (word_i)
        W_STAT:  rdata_o = {{(DATA_W-STAT_W){1'b0}}, status_i};
        W_CP_LO: rdata_o = cmd_ptr_i;
        W_ISEL:  rdata_o = isel_i;
        W_BSEL:  rdata_o = bsel_i;
        W_WSEL:  rdata_o = wsel_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic [DATA_W-1:0] intr_sel_o,
  output logic [DATA_W-1:0] br_sel_o,
  output logic [DATA_W-1:0] wait_sel_o,
  output logic              flush_req_o,
  output logic              kick_o,
  output logic              fetch_o
);
  logic [STAT_W-1:0] status_q, ctl_new;
  logic [DATA_W-1:0] cmd_ptr_q, isel_q, bsel_q, wsel_q;
  logic              ctl_flush, ctl_kick;
  logic              acc_ok, wr_ok;
  logic [WORD_W-1:0] word;

  assign acc_ok = (be_i == {BE_W{1'b1}}) && (addr_i[1:0] == 2'b00);
  assign word   = addr_i[ADDR_W-1:2];
  assign wr_ok  = we_i && acc_ok;

  dma_ctl_next u_ctl (
    .old_i   (status_q),
    .wdata_i (wdata_i),
    .new_o   (ctl_new),
    .flush_o (ctl_flush),
    .kick_o  (ctl_kick)
  );

  dma_rd_mux u_rd (
    .ok_i      (acc_ok),
    .word_i    (word),
    .status_i  (status_q),
    .cmd_ptr_i (cmd_ptr_q),
    .isel_i    (isel_q),
    .bsel_i    (bsel_q),
    .wsel_i    (wsel_q),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      cmd_ptr_q   <= '0;
      isel_q      <= '0;
      bsel_q      <= '0;
      wsel_q      <= '0;
      flush_req_o <= 1'b0;
      kick_o      <= 1'b0;
      fetch_o     <= 1'b0;
    end else begin
      flush_req_o <= 1'b0;
      kick_o      <= 1'b0;
      fetch_o     <= 1'b0;
      if (wr_ok) begin
        unique case (word)
          W_CTRL: begin
            status_q    <= ctl_new;
            flush_req_o <= ctl_flush;
            kick_o      <= ctl_kick;
          end
          W_CP_LO: if (!status_q[B_ACT]) begin
            cmd_ptr_q <= {wdata_i[DATA_W-1:4], 4'h0};
            fetch_o   <= 1'b1;
          end
          W_ISEL:  isel_q <= wdata_i;
          W_BSEL:  bsel_q <= wdata_i;
          W_WSEL:  wsel_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign status_o   = status_q;
  assign cmd_ptr_o  = cmd_ptr_q;
  assign intr_sel_o = isel_q;
  assign br_sel_o   = bsel_q;
  assign wait_sel_o = wsel_q;

  // R4
  pause_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[B_PAUSE] |-> !status_q[B_ACT]);
  // R5
  run_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_q[B_RUN]) && !status_q[B_RUN]) |-> !status_q[B_ACT]);
  // R6
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_q[B_FLUSH]);
  // R7
  kick_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_o |-> status_q[B_ACT]);
  // R9
  cp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_q[B_ACT]) |-> $stable(cmd_ptr_q));
  // R9
  cp_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ptr_q[3:0] == 4'h0);
  // R9
  fetch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |-> $past(!status_q[B_ACT]));
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = 4'hF;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, cmd_ptr_o, intr_sel_o, br_sel_o, wait_sel_o;
  logic [15:0] status_o;
  logic        flush_req_o, kick_o, fetch_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_stat = '0;
  logic [31:0] m_cp = '0, m_is = '0, m_bs = '0, m_ws = '0;

  always #2.5 clk_i = ~clk_i;

  dma_chan_regs i_dma_chan_regs (.*);

  function automatic logic [17:0] ctl_model(input logic [15:0] old, input logic [31:0] wd);
    logic [15:0] s;
    logic fl;
    s = ((wd[15:0] & 16'hF0FF) & wd[31:16]) | (old & ~wd[31:16]);
    if (s[12]) s[10] = 1'b1;
    if (s[15]) begin s[10] = 1'b1; s[11] = 1'b0; end
    if (s[14]) s[10] = 1'b0;
    if (old[15] && !s[15]) begin s[10] = 1'b0; s[11] = 1'b0; end
    fl = s[13];
    s[13] = 1'b0;
    return {s[10], fl, s};
  endfunction

  function automatic logic [31:0] rd_model(input logic [7:0] a, input logic [3:0] be);
    if (be != 4'hF || a[1:0] != 2'b00) return 32'h0;
    case (a[7:2])
      6'd1: return {16'h0, m_stat};
      6'd3: return m_cp;
      6'd4: return m_is;
      6'd5: return m_bs;
      6'd6: return m_ws;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be, input string req);
    logic ok;
    logic ef, ek, eft;
    logic [17:0] r;
    ok = (be == 4'hF) && (a[1:0] == 2'b00);
    ef = 0; ek = 0; eft = 0;
    if (ok) begin
      case (a[7:2])
        6'd0: begin r = ctl_model(m_stat, d); m_stat = r[15:0]; ef = r[16]; ek = r[17]; end
        6'd3: if (!m_stat[10]) begin m_cp = {d[31:4], 4'h0}; eft = 1; end
        6'd4: m_is = d;
        6'd5: m_bs = d;
        6'd6: m_ws = d;
        default: ;
      endcase
    end
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    we_i = 1'b0;
    chk({req, " flush"}, {31'h0, flush_req_o}, {31'h0, ef});
    chk({req, " kick"},  {31'h0, kick_o},      {31'h0, ek});
    chk({req, " fetch"}, {31'h0, fetch_o},     {31'h0, eft});
    chk({req, " status"}, {16'h0, status_o}, {16'h0, m_stat});
  endtask

  task automatic do_read(input logic [7:0] a, input logic [3:0] be, input string req);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a; be_i = be;
    #1 chk(req, rdata_o, rd_model(a, be));
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    #12 rst_ni = 1'b1;
    // R1 reset state
    for (int w = 0; w < 8; w++) do_read(8'(w*4), 4'hF, "R1 reset read");
    chk("R1 pulses", {29'h0, flush_req_o, kick_o, fetch_o}, 32'h0);
    // R8 selects, R9 pointer alignment and fetch
    do_write(8'h10, 32'hDEAD_BEEF, 4'hF, "R8 isel");
    do_write(8'h14, 32'h0F0F_1234, 4'hF, "R8 bsel");
    do_write(8'h18, 32'h8000_0001, 4'hF, "R8 wsel");
    do_write(8'h0C, 32'h0001_234F, 4'hF, "R9 cp idle");
    do_write(8'h08, 32'hFFFF_FFFF, 4'hF, "R8 cp hi write");
    do_write(8'h04, 32'hFFFF_FFFF, 4'hF, "R8 status write");
    for (int w = 0; w < 8; w++) do_read(8'(w*4), 4'hF, "R8 readback");
    // R2 dev status merge, mask on non-writable bits
    do_write(8'h00, 32'h00FF_00A5, 4'hF, "R2 devstat");
    do_write(8'h00, 32'h0F00_0F00, 4'hF, "R2 ro bits");
    // R3 wake activates, R9 cp ignored while active
    do_write(8'h00, 32'h1000_1000, 4'hF, "R3 wake");
    do_write(8'h0C, 32'h0000_5550, 4'hF, "R9 cp active");
    do_read(8'h0C, 4'hF, "R9 cp held");
    // R4 pause beats run
    do_write(8'h00, 32'hC000_C000, 4'hF, "R4 pause+run");
    do_write(8'h00, 32'h4000_0000, 4'hF, "R3 unpause run");
    // R5 run falls with wake
    do_write(8'h00, 32'h9000_1000, 4'hF, "R5 run fall");
    // R6 flush
    do_write(8'h00, 32'h2000_2000, 4'hF, "R6 flush");
    // R10 invalid accesses
    do_write(8'h10, 32'h1111_1111, 4'h3, "R10 partial wr");
    do_write(8'h01, 32'h8000_8000, 4'hF, "R10 misaligned wr");
    do_read(8'h11, 4'hF, "R10 misaligned rd");
    do_read(8'h10, 4'h1, "R10 partial rd");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [3:0] be;
      logic [31:0] d;
      a  = (($urandom % 4) == 0) ? 8'($urandom) : 8'(($urandom % 8) * 4);
      if (($urandom % 16) == 0) a[1:0] = 2'($urandom);
      be = (($urandom % 16) == 0) ? 4'($urandom) : 4'hF;
      d  = $urandom;
      if (a[7:2] == 0 && ($urandom % 3) == 0) d[31:16] = 16'h9000;
      do_write(a, d, be, "R2-R10 random");
      do_read(a, be, "R8 random read");
      do_read(8'h04, 4'hF, "R3 random status");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule